// File: doc/BRIEF.md
# Two-Segment SPI Frame Builder

This block turns one or two segment commands into a single SPI frame. A first-segment command (N1) and an optional second-segment command (N2) each name a byte count and whether that segment sends data, receives data, or both. Data bytes come from a 64-bit transmit data register (TDR). Byte offset 0 is bits 63:56, and the N2 segment continues from where the N1 transmit bytes stopped. A byte that carries no data becomes 0xFF, so the payload always has as many bytes as the frame is long. The payload is collected in a 16-byte transmit FIFO.

When a frame is complete, the payload is sent as SPI words of 1 to 4 bytes. The word exchange uses a request/response handshake, with at most one word in flight. The returned bytes go into a 16-byte receive FIFO. They are then streamed out one byte per cycle, and both FIFOs are emptied before the block takes the next command. Each command ends with a one-cycle done pulse. A stop indication goes with that pulse when the command refused to run and must be issued again later.

Top module: `seg_frame_shifter`

## Requirements
- R1: An N1 byte k carries TDR byte offset k (offset 0 = bits 63:56) when N1 transmit is enabled. It is 0xFF when N1 transmit is disabled, or when the offset is 8 or more.
- R2: An N2 byte k carries TDR offset T+k, where T is the N1 transmit byte count (0 if N1 did not transmit), only while N2 transmit is enabled and T+k < 8. Otherwise the byte is 0xFF.
- R3: The length of each segment is limited to 9 bytes when ecc_ctrl is 0 or 2, and to 8 bytes otherwise. A longer request is cut to the limit and raises cap_err until the next accepted command.
- R4: If a segment has receive enabled while rdr_full is high, the command ends with op_done and op_stop both high. No SPI word is sent and no payload byte is added. Payload already held from an earlier N1 stays in place for the retry.
- R5: An N2 command with no completed N1 since the last N2 frame raises no_n1_err and ends with op_done and op_stop, without sending anything.
- R6: An N1 command with next_is_n2 low is sent as a frame of its own. With next_is_n2 high, the N1 bytes are kept and go out in front of the N2 bytes in one frame, and the N1 command ends without any SPI word.
- R7: The payload is sent in words of word_len bytes, in order. The first byte is the most significant of the word's low word_len bytes. A short final word is filled with 0x00 bytes at its low end. A word_len of 0 or more than 4 means 4.
- R8: Each response word is split into bytes, most significant of its low word_len bytes first. Bytes past the payload length are dropped. The kept bytes are streamed out on rx_out_valid/rx_out_byte in order, before op_done.
- R9: Each FIFO holds 16 bytes. A push into a full FIFO is dropped and raises fifo_ovf until the next accepted command. Both FIFOs are empty at the start of the next frame.
- R10: When a frame that ends an N2 command with N2 transmit enabled completes, tdr_clr pulses together with op_done. No other frame pulses tdr_clr.
- R11: spi_req_valid holds with a stable word until spi_req_ready. After the handshake, no new request appears until spi_rsp_valid has returned that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Command strobe, taken when op_ready is high |
| op_ready | output | 1 | Block is idle and will take a command |
| op_is_n2 | input | 1 | 0 = N1 command, 1 = N2 command |
| next_is_n2 | input | 1 | An N2 command follows this N1 command |
| tdr | input | 64 | Transmit data register, offset 0 at bits 63:56 |
| n1_len | input | 4 | Requested N1 byte count |
| n1_tx_en | input | 1 | N1 transmits data |
| n1_rx_en | input | 1 | N1 receives data |
| n2_len | input | 4 | Requested N2 byte count |
| n2_tx_en | input | 1 | N2 transmits data |
| n2_rx_en | input | 1 | N2 receives data |
| ecc_ctrl | input | 2 | ECC control, selects the segment length limit |
| rdr_full | input | 1 | Receive data register is full |
| word_len | input | 3 | Bytes per SPI word |
| spi_req_valid | output | 1 | SPI word request |
| spi_req_ready | input | 1 | Request accepted |
| spi_req_word | output | 32 | Word to shift out |
| spi_rsp_valid | input | 1 | Response word present |
| spi_rsp_word | input | 32 | Word shifted in |
| rx_out_valid | output | 1 | Received byte present |
| rx_out_byte | output | 8 | Received byte |
| op_done | output | 1 | Command finished (pulse) |
| op_stop | output | 1 | Command stopped and must be retried (pulse) |
| tdr_clr | output | 1 | Clear the TDR-full status (pulse) |
| cap_err | output | 1 | A segment length was cut to the limit |
| no_n1_err | output | 1 | N2 command arrived without a completed N1 |
| fifo_ovf | output | 1 | A push to a full FIFO was dropped |

## Verification
The last N2 byte push of an oversize combined frame can meet a full transmit FIFO. In that cycle the dropped push and the overflow flag come together, and the trimmed payload then ends in a short word whose pad bytes must not reach the receive stream. The bench provokes this with a 9+9 byte frame sent as 3-byte words. It checks the 16 kept bytes, the zero pad in the sixth word, a stream of exactly 16 returned bytes, and an empty FIFO on the following frame. The frame end of an N2 transmit also brings op_done and tdr_clr in the same cycle, and both are checked together.

// File: rtl/seg_frame_shifter.sv
module seg_frame_shifter #(
  parameter int DEPTH = 16,
  parameter int MAXW  = 4,
  parameter int TDRB  = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 op_valid,
  output logic                 op_ready,
  input  logic                 op_is_n2,
  input  logic                 next_is_n2,
  input  logic [TDRB*8-1:0]    tdr,
  input  logic [3:0]           n1_len,
  input  logic                 n1_tx_en,
  input  logic                 n1_rx_en,
  input  logic [3:0]           n2_len,
  input  logic                 n2_tx_en,
  input  logic                 n2_rx_en,
  input  logic [1:0]           ecc_ctrl,
  input  logic                 rdr_full,
  input  logic [2:0]           word_len,
  output logic                 spi_req_valid,
  input  logic                 spi_req_ready,
  output logic [MAXW*8-1:0]    spi_req_word,
  input  logic                 spi_rsp_valid,
  input  logic [MAXW*8-1:0]    spi_rsp_word,
  output logic                 rx_out_valid,
  output logic [7:0]           rx_out_byte,
  output logic                 op_done,
  output logic                 op_stop,
  output logic                 tdr_clr,
  output logic                 cap_err,
  output logic                 no_n1_err,
  output logic                 fifo_ovf
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int WB = MAXW * 8;

  typedef enum logic [2:0] {S_IDLE, S_BUILD, S_SEND, S_WAIT, S_DRAIN} st_t;
  st_t st;

  logic [7:0]    tx_mem [DEPTH];
  logic [7:0]    rx_mem [DEPTH];
  logic [CW-1:0] tx_cnt, tx_rd, rx_cnt, rx_rd;
  logic          n1_done, seg_is_n2, seg_tx, send_after;
  logic [3:0]    n1_txb, seg_len, seg_k;
  logic          done_q, stop_q, clr_q, cap_q, non1_q, ovf_q;

  logic [3:0] lim, n1_cl, n2_cl;
  logic       n1_over, n2_over;
  assign lim     = (ecc_ctrl == 2'd0 || ecc_ctrl == 2'd2) ? 4'(TDRB + 1) : 4'(TDRB);
  assign n1_over = n1_len > lim;
  assign n2_over = n2_len > lim;
  assign n1_cl   = n1_over ? lim : n1_len;
  assign n2_cl   = n2_over ? lim : n2_len;

  logic [2:0] wl;
  assign wl = (word_len == 3'd0 || int'(word_len) > MAXW) ? 3'(MAXW) : word_len;

  logic [4:0] off;
  logic [7:0] bld_byte;
  always_comb begin
    off      = seg_is_n2 ? ({1'b0, n1_txb} + {1'b0, seg_k}) : {1'b0, seg_k};
    bld_byte = 8'hFF;
    if (seg_tx && int'(off) < TDRB) bld_byte = tdr[8*(TDRB-1-int'(off)) +: 8];
  end

  logic [CW:0] pi;
  always_comb begin
    spi_req_word = '0;
    pi = '0;
    for (int i = 0; i < MAXW; i++) begin
      if (i < int'(wl)) begin
        pi = {1'b0, tx_rd} + (CW+1)'(i);
        spi_req_word = (spi_req_word << 8) |
                       WB'((pi < {1'b0, tx_cnt}) ? tx_mem[pi[AW-1:0]] : 8'h00);
      end
    end
  end

  logic [MAXW-1:0] rx_we;
  logic [AW-1:0]   rx_wi [MAXW];
  logic [7:0]      rx_wb [MAXW];
  logic [CW:0]     pj, rk;
  logic            rx_drop;
  always_comb begin
    rk = {1'b0, rx_cnt};
    pj = '0;
    rx_drop = 1'b0;
    for (int i = 0; i < MAXW; i++) begin
      rx_we[i] = 1'b0;
      rx_wi[i] = '0;
      rx_wb[i] = 8'(spi_rsp_word >> (8 * (int'(wl) - 1 - i)));
      pj = {1'b0, tx_rd} + (CW+1)'(i);
      if (i < int'(wl) && pj < {1'b0, tx_cnt}) begin
        if (rk < (CW+1)'(DEPTH)) begin
          rx_we[i] = 1'b1;
          rx_wi[i] = rk[AW-1:0];
          rk = rk + 1'b1;
        end else rx_drop = 1'b1;
      end
    end
  end

  assign op_ready      = st == S_IDLE;
  assign spi_req_valid = st == S_SEND && tx_rd < tx_cnt;
  assign rx_out_valid  = st == S_DRAIN && rx_rd < rx_cnt;
  assign rx_out_byte   = rx_mem[rx_rd[AW-1:0]];
  assign op_done   = done_q;
  assign op_stop   = stop_q;
  assign tdr_clr   = clr_q;
  assign cap_err   = cap_q;
  assign no_n1_err = non1_q;
  assign fifo_ovf  = ovf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      tx_cnt <= '0; tx_rd <= '0; rx_cnt <= '0; rx_rd <= '0;
      n1_done <= 1'b0; n1_txb <= '0; seg_is_n2 <= 1'b0; seg_tx <= 1'b0;
      seg_len <= '0; seg_k <= '0; send_after <= 1'b0;
      done_q <= 1'b0; stop_q <= 1'b0; clr_q <= 1'b0;
      cap_q <= 1'b0; non1_q <= 1'b0; ovf_q <= 1'b0;
    end else begin
      done_q <= 1'b0; stop_q <= 1'b0; clr_q <= 1'b0;
      case (st)
        S_IDLE: if (op_valid) begin
          cap_q <= 1'b0; non1_q <= 1'b0; ovf_q <= 1'b0; seg_k <= '0;
          if (!op_is_n2) begin
            if (n1_rx_en && rdr_full) begin
              done_q <= 1'b1; stop_q <= 1'b1;
            end else begin
              cap_q <= n1_over; seg_len <= n1_cl; seg_tx <= n1_tx_en;
              seg_is_n2 <= 1'b0; n1_txb <= n1_tx_en ? n1_cl : 4'd0;
              send_after <= !next_is_n2; st <= S_BUILD;
            end
          end else if (!n1_done) begin
            non1_q <= 1'b1; done_q <= 1'b1; stop_q <= 1'b1;
          end else if (n2_rx_en && rdr_full) begin
            done_q <= 1'b1; stop_q <= 1'b1;
          end else begin
            cap_q <= n2_over; seg_len <= n2_cl; seg_tx <= n2_tx_en;
            seg_is_n2 <= 1'b1; send_after <= 1'b1; st <= S_BUILD;
          end
        end
        S_BUILD: if (seg_k == seg_len) begin
          if (!seg_is_n2) n1_done <= 1'b1;
          if (send_after) st <= S_SEND;
          else begin done_q <= 1'b1; st <= S_IDLE; end
        end else begin
          seg_k <= seg_k + 4'd1;
          if (tx_cnt < CW'(DEPTH)) begin
            tx_mem[tx_cnt[AW-1:0]] <= bld_byte;
            tx_cnt <= tx_cnt + 1'b1;
          end else ovf_q <= 1'b1;
        end
        S_SEND: begin
          if (tx_rd >= tx_cnt) st <= S_DRAIN;
          else if (spi_req_ready) st <= S_WAIT;
        end
        S_WAIT: if (spi_rsp_valid) begin
          for (int i = 0; i < MAXW; i++)
            if (rx_we[i]) rx_mem[rx_wi[i]] <= rx_wb[i];
          rx_cnt <= rk[CW-1:0];
          if (rx_drop) ovf_q <= 1'b1;
          tx_rd <= tx_rd + CW'(wl);
          st <= S_SEND;
        end
        S_DRAIN: begin
          if (rx_rd < rx_cnt) rx_rd <= rx_rd + 1'b1;
          else begin
            tx_cnt <= '0; tx_rd <= '0; rx_cnt <= '0; rx_rd <= '0;
            done_q <= 1'b1;
            if (seg_is_n2) begin n1_done <= 1'b0; clr_q <= seg_tx; end
            st <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    spi_req_valid && !spi_req_ready |=> spi_req_valid && $stable(spi_req_word));
  assert_one_outstanding_R11: assert property (@(posedge clk) disable iff (!rst_n)
    spi_req_valid && spi_req_ready |=> !spi_req_valid);
  assert_stop_has_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    op_stop |-> op_done && !spi_req_valid);
  assert_clr_at_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tdr_clr |-> op_done && !op_stop);
  assert_no_n1_stops_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(no_n1_err) |-> op_stop);
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= CW'(DEPTH) && rx_cnt <= tx_cnt);
  assert_drain_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_out_valid |-> !spi_req_valid && !op_ready);
endmodule

// File: tb/test_seg_frame_shifter.sv
module test_seg_frame_shifter;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic op_valid = 0, op_is_n2 = 0, next_is_n2 = 0;
  logic [63:0] tdr = 64'h1122_3344_5566_7788;
  logic [3:0] n1_len = 0, n2_len = 0;
  logic n1_tx_en = 0, n1_rx_en = 0, n2_tx_en = 0, n2_rx_en = 0;
  logic [1:0] ecc_ctrl = 2'd1;
  logic rdr_full = 0;
  logic [2:0] word_len = 3'd4;
  logic spi_req_ready = 0, spi_rsp_valid = 0;
  logic [31:0] spi_rsp_word = 0;
  logic op_ready, spi_req_valid, rx_out_valid, op_done, op_stop, tdr_clr;
  logic cap_err, no_n1_err, fifo_ovf;
  logic [31:0] spi_req_word;
  logic [7:0] rx_out_byte;

  seg_frame_shifter i_seg_frame_shifter (.*);

  int checks = 0, fails = 0;
  int nreq = 0, nrx = 0, ndone = 0, nclr = 0;
  logic last_stop = 0;
  logic [31:0] reqq [64];
  logic [7:0] rxq [64];
  int rdy_dly = 0, rsp_dly = 0;
  logic [7:0] expb [32];
  int nexp = 0, n1txb = 0;
  logic exp_ovf = 0;

  task automatic chk(input bit ok, input string r, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  initial forever begin
    @(negedge clk);
    if (rx_out_valid) begin rxq[nrx % 64] = rx_out_byte; nrx++; end
    if (op_done) begin ndone++; last_stop = op_stop; end
    if (tdr_clr) nclr++;
  end

  initial forever begin
    logic [31:0] w;
    @(negedge clk);
    if (spi_req_valid) begin
      w = spi_req_word;
      for (int d = 0; d < rdy_dly; d++) begin
        @(negedge clk);
        chk(spi_req_valid && spi_req_word == w, "R11 hold", spi_req_word, w);
      end
      reqq[nreq % 64] = w; nreq++;
      spi_req_ready = 1;
      @(negedge clk);
      spi_req_ready = 0;
      for (int d = 0; d < rsp_dly; d++) begin
        chk(!spi_req_valid, "R11 outstanding", spi_req_valid, 0);
        @(negedge clk);
      end
      chk(!spi_req_valid, "R11 outstanding", spi_req_valid, 0);
      spi_rsp_word = w ^ 32'hA5A5_A5A5; spi_rsp_valid = 1;
      @(negedge clk);
      spi_rsp_valid = 0;
    end
  end

  task automatic run_op(input logic is_n2, input logic nxt);
    int d0 = ndone;
    @(negedge clk);
    op_is_n2 = is_n2; next_is_n2 = nxt; op_valid = 1;
    @(negedge clk);
    op_valid = 0;
    for (int t = 0; t < 3000 && ndone == d0; t++) @(negedge clk);
  endtask

  task automatic exp_seg(input int len, input logic tx, input logic is_n2);
    int lim = (ecc_ctrl == 0 || ecc_ctrl == 2) ? 9 : 8;
    int l = len > lim ? lim : len;
    if (!is_n2) n1txb = tx ? l : 0;
    for (int k = 0; k < l; k++) begin
      int o = is_n2 ? n1txb + k : k;
      logic [7:0] b = (tx && o < 8) ? tdr[8*(7-o) +: 8] : 8'hFF;
      if (nexp < 16) begin expb[nexp] = b; nexp++; end else exp_ovf = 1;
    end
  endtask

  task automatic check_frame(input string r, input int rq0, input int rx0);
    int wl = (word_len == 0 || word_len > 4) ? 4 : int'(word_len);
    int nw = (nexp + wl - 1) / wl;
    chk(nreq - rq0 == nw, {r, " word count"}, nreq - rq0, nw);
    for (int j = 0; j < nw && j < nreq - rq0; j++) begin
      logic [31:0] w = 0;
      for (int i = 0; i < wl; i++)
        w = (w << 8) | 32'((j*wl + i < nexp) ? expb[j*wl + i] : 8'h00);
      chk(reqq[(rq0 + j) % 64] == w, {r, " word"}, reqq[(rq0 + j) % 64], w);
    end
    chk(nrx - rx0 == nexp, {r, " R8 rx count"}, nrx - rx0, nexp);
    for (int j = 0; j < nexp && j < nrx - rx0; j++)
      chk(rxq[(rx0 + j) % 64] == (expb[j] ^ 8'hA5), {r, " R8 rx byte"},
          rxq[(rx0 + j) % 64], expb[j] ^ 8'hA5);
    nexp = 0; exp_ovf = 0;
  endtask

  task automatic t_reset;
    chk(op_ready && !spi_req_valid && !rx_out_valid && !op_done, "R11 reset idle", op_ready, 1);
    chk(!cap_err && !no_n1_err && !fifo_ovf && !tdr_clr, "R9 reset flags",
        {cap_err, no_n1_err, fifo_ovf, tdr_clr}, 0);
  endtask

  task automatic t_n1_alone;
    int q0 = nreq, r0 = nrx, c0 = nclr;
    n1_len = 5; n1_tx_en = 1; n1_rx_en = 1; word_len = 4; rdy_dly = 2; rsp_dly = 3;
    run_op(0, 0); exp_seg(5, 1, 0);
    chk(!last_stop, "R6 N1 alone done", last_stop, 0);
    check_frame("R1 R7 N1 data", q0, r0);
    chk(nclr == c0, "R10 no clr after N1", nclr - c0, 0);
    q0 = nreq; r0 = nrx;
    n1_len = 3; n1_tx_en = 0; word_len = 2; rdy_dly = 0; rsp_dly = 0;
    run_op(0, 0); exp_seg(3, 0, 0);
    check_frame("R1 N1 fill", q0, r0);
  endtask

  task automatic t_combined;
    int q0 = nreq, r0 = nrx, c0 = nclr;
    n1_len = 3; n1_tx_en = 1; n1_rx_en = 0; word_len = 3; rsp_dly = 1;
    run_op(0, 1); exp_seg(3, 1, 0);
    chk(nreq == q0 && !last_stop, "R6 N1 held", nreq - q0, 0);
    n2_len = 7; n2_tx_en = 1; n2_rx_en = 1;
    run_op(1, 0); exp_seg(7, 1, 1);
    check_frame("R2 R6 combined", q0, r0);
    chk(nclr == c0 + 1, "R10 clr after N2 tx", nclr - c0, 1);
  endtask

  task automatic t_no_n1;
    int q0 = nreq;
    run_op(1, 0);
    chk(no_n1_err && last_stop, "R5 N2 without N1", {no_n1_err, last_stop}, 3);
    chk(nreq == q0, "R5 nothing sent", nreq - q0, 0);
  endtask

  task automatic t_rdr_full;
    int q0 = nreq, r0 = nrx, c0 = nclr;
    rdr_full = 1; n1_len = 2; n1_tx_en = 1; n1_rx_en = 1;
    run_op(0, 0);
    chk(last_stop && nreq == q0, "R4 N1 stop", last_stop, 1);
    n1_rx_en = 0; word_len = 4;
    run_op(0, 1); exp_seg(2, 1, 0);
    n2_len = 2; n2_tx_en = 0; n2_rx_en = 1;
    run_op(1, 0);
    chk(last_stop && nreq == q0, "R4 N2 stop", last_stop, 1);
    rdr_full = 0;
    run_op(1, 0); exp_seg(2, 0, 1);
    check_frame("R4 retry keeps N1", q0, r0);
    chk(nclr == c0, "R10 no clr N2 rx only", nclr - c0, 0);
  endtask

  task automatic t_cap;
    int q0 = nreq, r0 = nrx;
    ecc_ctrl = 1; n1_len = 12; n1_tx_en = 1; n1_rx_en = 0; word_len = 4;
    run_op(0, 0); exp_seg(12, 1, 0);
    chk(cap_err, "R3 cap 8", cap_err, 1);
    check_frame("R3 len 8", q0, r0);
    q0 = nreq; r0 = nrx; ecc_ctrl = 2;
    run_op(0, 0); exp_seg(12, 1, 0);
    chk(cap_err, "R3 cap 9", cap_err, 1);
    check_frame("R3 len 9", q0, r0);
    q0 = nreq; r0 = nrx; n1_len = 9;
    run_op(0, 0); exp_seg(9, 1, 0);
    chk(!cap_err, "R3 no cap", cap_err, 0);
    check_frame("R3 exact 9", q0, r0);
  endtask

  task automatic t_overflow;
    int q0 = nreq, r0 = nrx, c0 = nclr;
    ecc_ctrl = 0; n1_len = 9; n1_tx_en = 1; n2_len = 9; n2_tx_en = 1; n2_rx_en = 0;
    word_len = 3; rdy_dly = 1; rsp_dly = 2;
    run_op(0, 1); exp_seg(9, 1, 0);
    run_op(1, 0); exp_seg(9, 1, 1);
    chk(fifo_ovf && exp_ovf, "R9 overflow flag", fifo_ovf, 1);
    chk(nclr == c0 + 1, "R10 clr with done", nclr - c0, 1);
    check_frame("R9 R7 trimmed frame", q0, r0);
    q0 = nreq; r0 = nrx; n1_len = 2; word_len = 0;
    run_op(0, 0); exp_seg(2, 1, 0);
    chk(!fifo_ovf, "R9 flag cleared", fifo_ovf, 0);
    check_frame("R9 fifo reset", q0, r0);
  endtask

  bit ended = 0;
  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      ended = 1; checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_n1_alone();
    t_combined();
    t_no_n1();
    t_rdr_full();
    t_cap();
    t_overflow();
    repeat (5) @(negedge clk);
    if (!ended) begin
      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule